// File: doc/BRIEF.md
# Processor Internal Control Register Unit

This block executes the internal-control group of a processor's direct-write instruction. One command per cycle arrives as a function select and a 3-bit address field, qualified by a single-cycle strobe. The unit holds three kinds of state:

- a 4-bit condition code, loaded from four sense switches;
- three interrupt-inhibit flags, updated by set and clear masks;
- an alarm indicator and a program-controlled-frequency (PCF) flip-flop.

It also drives a speaker pin. The alarm tone is a square wave of fixed frequency, produced by dividing the system clock. The tone is gated by the run switch, the audio switch and the alarm. The PCF flip-flop reaches the same pin through the audio switch alone.

The command input has no ready signal and does not apply back-pressure. The unit accepts every strobe in the cycle it is asserted, and the register effects are visible after that clock edge. The switch and reset/clear inputs are level signals that are already synchronized to the clock.

Top module: `pcu_ctrl_unit`

## Requirements
- R1: After reset, the condition code, the inhibit flags, the alarm, the PCF flip-flop and the speaker are all 0.
- R2: A strobed command with op 0 copies sense_sw into cc, bit for bit, on that clock edge.
- R3: Op 1 sets each inhibit bit whose matching cmd_addr bit is 1 (cmd_addr[i] pairs with inhibit[i]). Inhibit bits paired with a 0 keep their value.
- R4: Op 2 clears each inhibit bit whose matching cmd_addr bit is 1. Inhibit bits paired with a 0 keep their value.
- R5: Op 3 sets the alarm, and op 4 clears it.
- R6: A high cpu_clear or sys_clear clears the alarm on that edge. This holds even when op 3 is strobed in the same cycle.
- R7: Op 5 inverts the PCF flip-flop and clears the alarm.
- R8: While alarm, run_sw and audio_sw are all 1, the speaker carries a square wave that starts low. Each half-period lasts CLK_HZ/2000 cycles. When any of the three inputs drops, the tone stops at once, and it restarts low when the gate reopens.
- R9: The speaker is the OR of the gated tone and (pcf AND audio_sw). PCF never reaches the speaker while audio_sw is 0.
- R10: A cycle with cmd_valid low changes no register. A strobed op 6 or op 7 also changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Single-cycle command strobe |
| cmd_op | input | 3 | Function select (0 sense, 1 inhibit set, 2 inhibit clear, 3 alarm set, 4 alarm clear, 5 PCF toggle) |
| cmd_addr | input | 3 | Inhibit mask field |
| sense_sw | input | 4 | Sense switch levels |
| cpu_clear | input | 1 | CPU reset/clear level, clears alarm |
| sys_clear | input | 1 | System reset/clear level, clears alarm |
| run_sw | input | 1 | Run/idle switch, 1 = run |
| audio_sw | input | 1 | Audio switch, 1 = on |
| cc | output | 4 | Condition code |
| inhibit | output | 3 | Interrupt-inhibit flags |
| alarm | output | 1 | Alarm indicator |
| pcf | output | 1 | PCF flip-flop |
| speaker | output | 1 | Speaker drive |

## Verification
The bench targets the following corner cases:

- **Mask with a zero bit.** An inhibit set or clear whose mask has a 0 in some bit must leave that inhibit bit alone. A design that loads the mask instead of merging it would visibly wipe the unmasked flags.
- **Clear racing set.** A reset/clear pulse in the same cycle as an alarm-set command must win. A design with the wrong priority would leave the alarm on.
- **Tone half-period edges.** The tone is sampled exactly on both sides of its first two half-period edges. An off-by-one divider would show a level one cycle early or late.
- **Tone restart and PCF gating.** Dropping run_sw and then restoring it must restart the tone low. With audio off and PCF set, the speaker must stay silent; a design that skipped this gate would leak the PCF level.
- **No-effect cycles.** Unstrobed cycles and the unused op codes are shown to change no register.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  localparam int CC_W  = 4;
  localparam int INH_W = 3;
  localparam int OP_W  = 3;

  typedef enum logic [OP_W-1:0] {
    OP_SENSE   = 3'd0,
    OP_INH_SET = 3'd1,
    OP_INH_CLR = 3'd2,
    OP_ALM_SET = 3'd3,
    OP_ALM_CLR = 3'd4,
    OP_PCF_TGL = 3'd5
  } pcu_op_e;

  typedef struct packed {
    logic sense;
    logic inh_set;
    logic inh_clr;
    logic alm_set;
    logic alm_clr;
    logic pcf_tgl;
  } pcu_strobe_t;
endpackage

// File: rtl/pcu_load_reg.sv
module pcu_load_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/pcu_mask_reg.sv
module pcu_mask_reg #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] mask,
  output logic [W-1:0] q
);
  // each bit is its own flop with a private set/clear term
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    q[i] <= 1'b0;
      else if (clr_en && mask[i])    q[i] <= 1'b0;
      else if (set_en && mask[i])    q[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/pcu_alarm_pcf.sv
module pcu_alarm_pcf (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_clear,
  input  logic alm_set,
  input  logic alm_clr,
  input  logic pcf_tgl,
  output logic alarm,
  output logic pcf
);
  logic alarm_kill;
  assign alarm_kill = ext_clear | alm_clr | pcf_tgl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          alarm <= 1'b0;
    else if (alarm_kill) alarm <= 1'b0;
    else if (alm_set)    alarm <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcf <= 1'b0;
    else if (pcf_tgl) pcf <= ~pcf;
  end
endmodule

// File: rtl/pcu_tone_div.sv
module pcu_tone_div #(
  parameter int HALF = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic sq
);
  localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sq  <= 1'b0;
    end else if (!en) begin
      cnt <= '0;
      sq  <= 1'b0;
    end else if (cnt == LAST) begin
      cnt <= '0;
      sq  <= ~sq;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pcu_ctrl_unit.sv
module pcu_ctrl_unit
  import pcu_pkg::*;
#(
  parameter int CLK_HZ  = 100_000_000,
  parameter int TONE_HZ = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [OP_W-1:0]  cmd_op,
  input  logic [INH_W-1:0] cmd_addr,
  input  logic [CC_W-1:0]  sense_sw,
  input  logic             cpu_clear,
  input  logic             sys_clear,
  input  logic             run_sw,
  input  logic             audio_sw,
  output logic [CC_W-1:0]  cc,
  output logic [INH_W-1:0] inhibit,
  output logic             alarm,
  output logic             pcf,
  output logic             speaker
);
  localparam int HALF_RAW = CLK_HZ / (2 * TONE_HZ);
  localparam int HALF     = (HALF_RAW < 1) ? 1 : HALF_RAW;

  pcu_strobe_t stb;

  always_comb begin
    stb = '0;
    if (cmd_valid) begin
      case (pcu_op_e'(cmd_op))
        OP_SENSE:   stb.sense   = 1'b1;
        OP_INH_SET: stb.inh_set = 1'b1;
        OP_INH_CLR: stb.inh_clr = 1'b1;
        OP_ALM_SET: stb.alm_set = 1'b1;
        OP_ALM_CLR: stb.alm_clr = 1'b1;
        OP_PCF_TGL: stb.pcf_tgl = 1'b1;
        default:    stb = '0;
      endcase
    end
  end

  pcu_load_reg #(.W(CC_W)) u_cc (
    .clk(clk), .rst_n(rst_n), .load(stb.sense), .d(sense_sw), .q(cc)
  );

  pcu_mask_reg #(.W(INH_W)) u_inh (
    .clk(clk), .rst_n(rst_n), .set_en(stb.inh_set), .clr_en(stb.inh_clr),
    .mask(cmd_addr), .q(inhibit)
  );

  pcu_alarm_pcf u_alm (
    .clk(clk), .rst_n(rst_n), .ext_clear(cpu_clear | sys_clear),
    .alm_set(stb.alm_set), .alm_clr(stb.alm_clr), .pcf_tgl(stb.pcf_tgl),
    .alarm(alarm), .pcf(pcf)
  );

  logic tone_en, tone_sq;
  assign tone_en = alarm & run_sw & audio_sw;

  pcu_tone_div #(.HALF(HALF)) u_tone (
    .clk(clk), .rst_n(rst_n), .en(tone_en), .sq(tone_sq)
  );

  assign speaker = (tone_sq & tone_en) | (pcf & audio_sw);
endmodule

// File: rtl/pcu_ctrl_unit_chk.sv
module pcu_ctrl_unit_chk
  import pcu_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [OP_W-1:0]  cmd_op,
  input logic [INH_W-1:0] cmd_addr,
  input logic [CC_W-1:0]  sense_sw,
  input logic             cpu_clear,
  input logic             sys_clear,
  input logic             run_sw,
  input logic             audio_sw,
  input logic [CC_W-1:0]  cc,
  input logic [INH_W-1:0] inhibit,
  input logic             alarm,
  input logic             pcf,
  input logic             speaker
);
  p_sense_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd0) |=> cc == $past(sense_sw));

  p_inh_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd1) |=> inhibit == ($past(inhibit) | $past(cmd_addr)));

  p_inh_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd2) |=> inhibit == ($past(inhibit) & ~$past(cmd_addr)));

  p_ext_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clear || sys_clear) |=> !alarm);

  p_pcf_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd5) |=> (pcf != $past(pcf)) && !alarm);

  p_tone_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_sw && !pcf) |-> !speaker);

  p_audio_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !audio_sw |-> !speaker);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid && !cpu_clear && !sys_clear) |=>
      $stable(cc) && $stable(inhibit) && $stable(alarm) && $stable(pcf));
endmodule

bind pcu_ctrl_unit pcu_ctrl_unit_chk u_chk (.*);

// File: tb/pcu_ctrl_unit_bench.sv
module pcu_ctrl_unit_bench;
  localparam int CLK_HZ = 20000;
  localparam int HALF   = CLK_HZ / 2000;

  typedef struct packed {
    logic [3:0] cc;
    logic [2:0] inh;
    logic       alarm;
    logic       pcf;
  } state_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0, cmd_addr = '0;
  logic [3:0] sense_sw = '0;
  logic cpu_clear = 1'b0, sys_clear = 1'b0, run_sw = 1'b0, audio_sw = 1'b0;
  logic [3:0] cc;
  logic [2:0] inhibit;
  logic alarm, pcf, speaker;

  int checks = 0, failures = 0;
  state_t model = '0;
  state_t exp_q[$];
  string  tag_q[$];

  always #2 clk = ~clk;

  pcu_ctrl_unit #(.CLK_HZ(CLK_HZ)) u_pcu_ctrl_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .sense_sw(sense_sw), .cpu_clear(cpu_clear),
    .sys_clear(sys_clear), .run_sw(run_sw), .audio_sw(audio_sw),
    .cc(cc), .inhibit(inhibit), .alarm(alarm), .pcf(pcf), .speaker(speaker)
  );

  task automatic check_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus, updates model, queues expectation
  task automatic drive(input string req, input logic v, input logic [2:0] op,
                       input logic [2:0] addr, input logic cpuc, input logic sysc);
    @(negedge clk);
    cmd_valid = v; cmd_op = op; cmd_addr = addr;
    cpu_clear = cpuc; sys_clear = sysc;
    @(posedge clk);
    #1;
    cmd_valid = 1'b0; cpu_clear = 1'b0; sys_clear = 1'b0;
    if (v) begin
      case (op)
        3'd0: model.cc = sense_sw;
        3'd1: model.inh = model.inh | addr;
        3'd2: model.inh = model.inh & ~addr;
        3'd3: model.alarm = 1'b1;
        3'd4: model.alarm = 1'b0;
        3'd5: begin model.pcf = ~model.pcf; model.alarm = 1'b0; end
        default: ;
      endcase
    end
    if (cpuc || sysc) model.alarm = 1'b0;
    exp_q.push_back(model);
    tag_q.push_back(req);
  endtask

  // monitor: compares design state against queued expectations
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      state_t e;
      state_t a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {cc, inhibit, alarm, pcf};
      checks++;
      if (a !== e) begin
        failures++;
        $display("FAIL %s actual=%h expected=%h", t, a, e);
      end
    end
  end

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check_bit("R1 cc", |cc, 1'b0);
    check_bit("R1 inhibit", |inhibit, 1'b0);
    check_bit("R1 alarm", alarm, 1'b0);
    check_bit("R1 pcf", pcf, 1'b0);
    check_bit("R1 speaker", speaker, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    // R2 sense copy
    sense_sw = 4'b1010; drive("R2", 1, 3'd0, 3'b000, 0, 0);
    sense_sw = 4'b0101; drive("R2", 1, 3'd0, 3'b111, 0, 0);
    // R3 mask set, R4 mask clear
    drive("R3", 1, 3'd1, 3'b101, 0, 0);
    drive("R3", 1, 3'd1, 3'b010, 0, 0);
    drive("R4", 1, 3'd2, 3'b001, 0, 0);
    drive("R4", 1, 3'd2, 3'b000, 0, 0);
    // R10 unstrobed and unused codes
    sense_sw = 4'b1111;
    drive("R10", 0, 3'd0, 3'b111, 0, 0);
    drive("R10", 0, 3'd2, 3'b111, 0, 0);
    drive("R10", 1, 3'd6, 3'b111, 0, 0);
    drive("R10", 1, 3'd7, 3'b111, 0, 0);

    // R5 / R8 alarm and tone
    run_sw = 1'b1; audio_sw = 1'b1;
    drive("R5", 1, 3'd3, 3'b000, 0, 0);
    repeat (HALF) @(negedge clk);
    check_bit("R8 tone low first half", speaker, 1'b0);
    @(negedge clk);
    check_bit("R8 tone rises", speaker, 1'b1);
    repeat (HALF - 1) @(negedge clk);
    check_bit("R8 tone high second half", speaker, 1'b1);
    @(negedge clk);
    check_bit("R8 tone falls", speaker, 1'b0);
    repeat (HALF / 2) @(negedge clk);
    run_sw = 1'b0;
    @(negedge clk);
    check_bit("R8 run off mutes", speaker, 1'b0);
    run_sw = 1'b1;
    @(negedge clk);
    check_bit("R8 restart low", speaker, 1'b0);
    repeat (HALF - 1) @(negedge clk);
    check_bit("R8 restart full half", speaker, 1'b1);
    drive("R5", 1, 3'd4, 3'b000, 0, 0);
    @(negedge clk);
    check_bit("R5 clear mutes", speaker, 1'b0);

    // R6 external clears
    drive("R5", 1, 3'd3, 3'b000, 0, 0);
    drive("R6", 0, 3'd0, 3'b000, 1, 0);
    drive("R5", 1, 3'd3, 3'b000, 0, 0);
    drive("R6", 1, 3'd3, 3'b000, 0, 1);

    // R7 toggle clears alarm, R9 PCF gating
    drive("R5", 1, 3'd3, 3'b000, 0, 0);
    drive("R7", 1, 3'd5, 3'b000, 0, 0);
    @(negedge clk);
    check_bit("R9 pcf audible", speaker, 1'b1);
    audio_sw = 1'b0;
    @(negedge clk);
    check_bit("R9 audio off mutes pcf", speaker, 1'b0);
    drive("R7", 1, 3'd5, 3'b000, 0, 0);
    audio_sw = 1'b1;
    @(negedge clk);
    check_bit("R9 pcf low silent", speaker, 1'b0);

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule